// File: doc/BRIEF.md
# Unit Clause Implication Detector

This block keeps the literal states of every clause of a satisfiability problem in an on-chip status array, one packed word per clause, indexed by a clause number. A solver core sends an update that names a clause, a literal slot inside it and the new state of that slot. The block reads the stored word, patches the one slot and tests the patched word. It then writes the word back and reports the outcome two clock edges after the request.

The test looks for the case where exactly one slot is still open and every other slot is false. In that case the open literal is forced to true, and the block returns the clause number and the slot number of the forced literal. When every slot is false, the block raises a conflict flag instead. A clause with any true slot is satisfied and yields nothing.

Clauses shorter than the configured width are padded by writing false into their spare slots, so the padding never hides a forced literal. Updates may be issued every cycle, including back to back on one clause.

Top module: `clause_unit_detect`

## Requirements
- R1: Each slot state is 2 bits: 00 false, 01 true, 10 open. On reset every slot of every clause is 10.
- R2: An update sampled with `upd_valid` high at clock edge n replaces slot `upd_pid` of clause `upd_cid` with `upd_status`. The result of that update is visible on the outputs for the one cycle after edge n+1.
- R3: If, after the update, the clause holds exactly one slot at 10 and all its other slots at 00, `imp_valid` is 1. In that case `imp_pid` is the index of that slot and `imp_cid` is the updated clause.
- R4: If, after the update, every slot of the clause is 00, `conflict` is 1 and `imp_valid` is 0.
- R5: If, after the update, any slot of the clause is 01, neither `imp_valid` nor `conflict` is raised.
- R6: If, after the update, two or more slots are 10 and none is 01, neither `imp_valid` nor `conflict` is raised.
- R7: An update whose status is 11 is dropped. It changes no stored slot and raises neither output.
- R8: An update to the same clause in the very next cycle sees the slot written by the previous update.
- R9: Cycles without an update raise neither `imp_valid` nor `conflict`. Both outputs are 0 during and straight after reset.
- R10: An update touches only the addressed clause. The stored states of all other clauses stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Update request present |
| upd_cid | input | CW = clog2(NC) | Clause number to update |
| upd_pid | input | PW = clog2(K) | Slot index inside the clause |
| upd_status | input | 2 | New slot state (00 false, 01 true, 10 open) |
| imp_valid | output | 1 | A forced literal was found |
| imp_cid | output | CW | Clause holding the forced literal |
| imp_pid | output | PW | Slot of the forced literal |
| conflict | output | 1 | Every slot of the updated clause is false |

## Verification
The bench builds the block with four slots per clause and four clauses. This makes every one of the 81 legal state combinations of a clause reachable through back-to-back slot writes. The sweep is run once on a single clause per pattern, which exercises same-clause forwarding. It is run again with writes alternating between two clauses, which checks that clauses stay isolated. Illegal 11 writes, idle gaps and a fresh clause padded with false slots cover the reset state and dropped requests.

// File: rtl/clause_unit_pkg.sv
package clause_unit_pkg;
   localparam logic [1:0] ST_FALSE = 2'b00;
   localparam logic [1:0] ST_TRUE  = 2'b01;
   localparam logic [1:0] ST_OPEN  = 2'b10;
   localparam logic [1:0] ST_BAD   = 2'b11;

   // build a packed clause word with every slot set to one state
   function automatic logic [63:0] fill_word(input int slots, input logic [1:0] st);
      logic [63:0] w;
      w = '0;
      for (int i = 0; i < slots; i++) w[2*i +: 2] = st;
      return w;
   endfunction
endpackage

// File: rtl/clause_status_ram.sv
module clause_status_ram #(
   parameter int NC = 32,
   parameter int FW = 8,
   parameter int CW = 5,
   parameter logic [FW-1:0] INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] rd_addr,
   output logic [FW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [CW-1:0] wr_addr,
   input  logic [FW-1:0] wr_data
);
   generate
      if (NC < 2) begin : g_bad_depth
         $error("clause_status_ram: NC must be at least 2");
      end
      if ((1 << CW) < NC) begin : g_bad_addr
         $error("clause_status_ram: CW too narrow for NC");
      end
   endgenerate

   logic [FW-1:0] cells [NC];
   logic          fwd_hit;

   assign fwd_hit = wr_en && (wr_addr == rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < NC; n++) cells[n] <= INIT;
         rd_data <= INIT;
      end else begin
         if (wr_en) cells[wr_addr] <= wr_data;
         // same-clause write this edge is passed straight to the reader
         rd_data <= fwd_hit ? wr_data : cells[rd_addr];
      end
   end

   // R8: a read that collides with a write returns the written word
   a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == rd_addr) |=> (rd_data == $past(wr_data)));
endmodule

// File: rtl/clause_unit_eval.sv
module clause_unit_eval
   import clause_unit_pkg::*;
#(
   parameter int K  = 4,
   parameter int PW = 2
) (
   input  logic [2*K-1:0] fields,
   output logic           hit,
   output logic [PW-1:0]  pos,
   output logic           all_false,
   output logic           any_true
);
   logic [K-1:0] is_zero;
   logic [K-1:0] is_open;
   logic [K-1:0] is_true;
   logic [K-1:0] unit_vec;

   generate
      for (genvar i = 0; i < K; i++) begin : g_slot
         logic [K-1:0] rest_ok;
         assign is_zero[i] = (fields[2*i +: 2] == ST_FALSE);
         assign is_open[i] = (fields[2*i +: 2] == ST_OPEN);
         assign is_true[i] = (fields[2*i +: 2] == ST_TRUE);
         // slot i is forced when it is open and every other slot is false
         assign rest_ok     = is_zero | (K'(1) << i);
         assign unit_vec[i] = is_open[i] && (&rest_ok);
      end
   endgenerate

   always_comb begin
      pos = '0;
      for (int i = 0; i < K; i++) begin
         if (unit_vec[i]) pos = PW'(i);
      end
   end

   assign hit       = |unit_vec;
   assign all_false = &is_zero;
   assign any_true  = |is_true;

   // R5: a forced literal never coexists with a true slot
   always_comb begin
      a_r5_no_unit_when_sat: assert (!(hit && any_true) || $isunknown(fields));
   end
endmodule

// File: rtl/clause_unit_detect.sv
module clause_unit_detect
   import clause_unit_pkg::*;
#(
   parameter int K  = 4,
   parameter int NC = 32,
   localparam int PW = (K > 1) ? $clog2(K) : 1,
   localparam int CW = (NC > 1) ? $clog2(NC) : 1,
   localparam int FW = 2 * K
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_valid,
   input  logic [CW-1:0] upd_cid,
   input  logic [PW-1:0] upd_pid,
   input  logic [1:0]    upd_status,
   output logic          imp_valid,
   output logic [CW-1:0] imp_cid,
   output logic [PW-1:0] imp_pid,
   output logic          conflict
);
   generate
      if (K < 2 || K > 32) begin : g_bad_k
         $error("clause_unit_detect: K must be within 2..32");
      end
   endgenerate

   localparam logic [63:0]   OPEN_ALL = fill_word(K, ST_OPEN);
   localparam logic [FW-1:0] INIT_W   = OPEN_ALL[FW-1:0];

   // stage 1: request captured while the clause word is read
   logic          s1_valid;
   logic [CW-1:0] s1_cid;
   logic [PW-1:0] s1_pid;
   logic [1:0]    s1_st;
   logic          s1_we;

   logic [FW-1:0] rd_q;
   logic [FW-1:0] merged;
   logic          u_hit;
   logic [PW-1:0] u_pos;
   logic          u_all_false;
   logic          u_any_true;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_cid   <= '0;
         s1_pid   <= '0;
         s1_st    <= ST_FALSE;
      end else begin
         s1_valid <= upd_valid;
         s1_cid   <= upd_cid;
         s1_pid   <= upd_pid;
         s1_st    <= upd_status;
      end
   end

   assign s1_we = s1_valid && (s1_st != ST_BAD);

   clause_status_ram #(
      .NC   (NC),
      .FW   (FW),
      .CW   (CW),
      .INIT (INIT_W)
   ) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (upd_cid),
      .rd_data (rd_q),
      .wr_en   (s1_we),
      .wr_addr (s1_cid),
      .wr_data (merged)
   );

   generate
      for (genvar i = 0; i < K; i++) begin : g_merge
         assign merged[2*i +: 2] = (s1_pid == PW'(i)) ? s1_st : rd_q[2*i +: 2];
      end
   endgenerate

   clause_unit_eval #(
      .K  (K),
      .PW (PW)
   ) u_eval (
      .fields    (merged),
      .hit       (u_hit),
      .pos       (u_pos),
      .all_false (u_all_false),
      .any_true  (u_any_true)
   );

   // stage 2: registered verdict
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imp_valid <= 1'b0;
         imp_cid   <= '0;
         imp_pid   <= '0;
         conflict  <= 1'b0;
      end else begin
         imp_valid <= s1_we && u_hit;
         imp_cid   <= s1_cid;
         imp_pid   <= u_hit ? u_pos : '0;
         conflict  <= s1_we && u_all_false;
      end
   end

   // R4: conflict and implication are exclusive
   a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(imp_valid && conflict));

   // R2: any verdict traces back to a request held one cycle earlier
   a_r2_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (imp_valid || conflict) |-> $past(s1_valid));

   // R3: the reported clause is the one that was updated
   a_r3_cid: assert property (@(posedge clk) disable iff (!rst_n)
      imp_valid |-> (imp_cid == $past(s1_cid)));

   // R7: illegal status yields no verdict
   a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_st == ST_BAD) |=> !(imp_valid || conflict));

   // R5: a satisfied merged clause yields no verdict
   a_r5_sat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_we && u_any_true) |=> !(imp_valid || conflict));
endmodule

// File: tb/tb_clause_unit_detect.sv
`timescale 1ns/1ps
module tb_clause_unit_detect;
   localparam int K  = 4;
   localparam int NC = 4;
   localparam int PW = 2;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          upd_valid = 1'b0;
   logic [CW-1:0] upd_cid = '0;
   logic [PW-1:0] upd_pid = '0;
   logic [1:0]    upd_status = 2'b00;
   logic          imp_valid;
   logic [CW-1:0] imp_cid;
   logic [PW-1:0] imp_pid;
   logic          conflict;

   always #4 clk = ~clk;   // 125 MHz

   clause_unit_detect #(.K(K), .NC(NC)) dut (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_cid(upd_cid),
      .upd_pid(upd_pid), .upd_status(upd_status), .imp_valid(imp_valid),
      .imp_cid(imp_cid), .imp_pid(imp_pid), .conflict(conflict));

   int total = 0;
   int bad   = 0;
   logic [1:0] mdl [NC][K];

   // expectation pipeline: e1 = driven last step, e2 = due now
   logic e1_imp = 0, e2_imp = 0, e1_con = 0, e2_con = 0;
   int   e1_pid = 0, e2_pid = 0, e1_cid = 0, e2_cid = 0;
   string e1_tag = "R9", e2_tag = "R9";

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic send(input bit v, input int cid, input int pid, input logic [1:0] st);
      int nz, no, nt, opos;
      bit x_imp, x_con;
      string tag;
      @(negedge clk);
      // R2: result of request driven two steps ago is visible now
      chk(e2_tag, "imp_valid", int'(imp_valid), int'(e2_imp));
      chk(e2_tag, "conflict", int'(conflict), int'(e2_con));
      if (e2_imp) begin
         chk(e2_tag, "imp_pid", int'(imp_pid), e2_pid);
         chk(e2_tag, "imp_cid", int'(imp_cid), e2_cid);
      end
      x_imp = 0; x_con = 0; opos = 0; tag = "R9";
      if (v && st == 2'b11) tag = "R7";
      else if (v) begin
         mdl[cid][pid] = st;
         nz = 0; no = 0; nt = 0;
         for (int i = 0; i < K; i++) begin
            if (mdl[cid][i] == 2'b00) nz++;
            if (mdl[cid][i] == 2'b10) begin no++; opos = i; end
            if (mdl[cid][i] == 2'b01) nt++;
         end
         if (nt > 0) tag = "R5";
         else if (nz == K) begin x_con = 1; tag = "R4"; end
         else if (no == 1 && nz == K - 1) begin x_imp = 1; tag = "R3"; end
         else tag = "R6";
      end
      e2_imp = e1_imp; e2_con = e1_con; e2_pid = e1_pid; e2_cid = e1_cid; e2_tag = e1_tag;
      e1_imp = x_imp;  e1_con = x_con;  e1_pid = opos;   e1_cid = cid;    e1_tag = tag;
      upd_valid  = v;
      upd_cid    = CW'(cid);
      upd_pid    = PW'(pid);
      upd_status = st;
   endtask

   function automatic logic [1:0] digit(input int p, input int j);
      int d;
      d = p;
      for (int n = 0; n < j; n++) d = d / 3;
      d = d % 3;
      return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b10;
   endfunction

   initial begin
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < K; i++) mdl[c][i] = 2'b10;   // R1 reset state
      repeat (3) @(negedge clk);
      // R9: quiet outputs in reset
      chk("R9", "imp_valid in reset", int'(imp_valid), 0);
      chk("R9", "conflict in reset", int'(conflict), 0);
      rst_n = 1'b1;
      send(0, 0, 0, 2'b00);
      // R1: fresh clause padded with false slots forces the last open slot
      send(1, 3, 0, 2'b00);
      send(1, 3, 1, 2'b00);
      send(1, 3, 2, 2'b00);
      send(0, 0, 0, 2'b00);
      // R8: full sweep, back-to-back writes on one clause
      for (int p = 0; p < 81; p++)
         for (int j = 0; j < K; j++) send(1, p % NC, j, digit(p, j));
      // R10: same sweep alternating between two clauses
      for (int p = 0; p < 81; p++)
         for (int j = 0; j < K; j++) send(1, 1 + (j % 2), j, digit(80 - p, j));
      // R7: illegal writes, then probe that stored state is unchanged
      for (int c = 0; c < NC; c++) begin
         send(1, c, c % K, 2'b11);
         send(0, 0, 0, 2'b00);
         send(1, c, (c + 1) % K, mdl[c][(c + 1) % K]);
      end
      // R4 then R3: drive clause 0 to all false, reopen one slot
      for (int j = 0; j < K; j++) send(1, 0, j, 2'b00);
      send(1, 0, 2, 2'b10);
      send(0, 0, 0, 2'b00);
      send(0, 0, 0, 2'b00);
      send(0, 0, 0, 2'b00);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule